// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a four-beat burst on a synchronous memory port. On each active clock edge it either captures a new starting address, or it moves on to the next beat of the current burst. The order of the beats is fixed when the burst starts. A mode input picks one of two orders. The sequential order counts the two lowest address bits upward and wraps within the group of four. The interleaved order XORs the beat number into those two bits. After four advances the address is back at the starting address, and the burst begins again.

Only the two lowest address bits move. All higher bits keep the value captured at the start. A stall input freezes the whole block. While it is high, the block ignores both a load and an advance. The output address and the beat number come straight from registers, through a small amount of logic, so they change one edge after the command that moves them. An asynchronous active-low reset is released synchronously to the clock.

Top module: `bag_burst_addr_gen`

## Requirements
- R1: Once reset has been applied, `addr_o` reads 0 and `beat_o` reads 0.
- R2: A cycle with `hold_i`=0 and `adv_i`=0 is a load. After that edge, `addr_o` equals `start_i` as sampled at the edge, and `beat_o` is 0.
- R3: With the order mode at 0 (sequential), bits [1:0] of `addr_o` equal (start bits [1:0] + `beat_o`) modulo 4. Example: from a start of 01, the bits go 01, 10, 11, 00.
- R4: With the order mode at 1 (interleaved), bits [1:0] of `addr_o` equal start bits [1:0] XOR `beat_o`. Example: from a start of 01, the bits go 01, 00, 11, 10.
- R5: After four advances from a load, `addr_o` equals the loaded start address again and `beat_o` is 0.
- R6: An advance never changes `addr_o` bits above bit 1.
- R7: While `hold_i`=1, `addr_o` and `beat_o` keep their values at the next edge, whatever `adv_i`, `mode_i` and `start_i` are.
- R8: `mode_i` is sampled only at a load. A change of `mode_i` during a burst has no effect until the next load.
- R9: A cycle with `hold_i`=0 and `adv_i`=1 is an advance. Each advance steps `beat_o` by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Stall: when high, all other inputs are ignored |
| adv_i | input | 1 | 1 = advance to the next beat, 0 = load `start_i` |
| mode_i | input | 1 | Burst order at load: 0 sequential, 1 interleaved |
| start_i | input | ADDR_W (19) | Starting address of the burst |
| addr_o | output | ADDR_W (19) | Address of the current beat |
| beat_o | output | BEAT_W (2) | Position within the burst, 0 to 3 |

## Verification
The assertions are checked on every clock cycle. They cover these behaviours:
- A stall freezes both outputs.
- A load clears the beat number.
- An advance steps the beat by one and leaves the upper address bits untouched.
- In sequential mode the low bits increase by one per advance.
- In interleaved mode the change in the low bits equals the change in the beat number.
- The latched mode and the captured start change only on a load.

Some behaviours can only be shown by the bench scenarios, which compare the design against a behavioural model on every clock:
- the full sequences from all four starting offsets in both orders;
- the return to the start address after four beats;
- a flip of `mode_i` in mid-burst that has no effect;
- loads and advances that arrive during a stall and are ignored.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/bag_rst_sync.sv
module bag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              inc,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (en) begin
      if (clr)      beat_d = '0;
      else if (inc) beat_d = (beat_q == LAST) ? '0 : beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  // R2
  load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (beat_o == '0));

  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && inc) |=>
      (beat_o == (($past(beat_o) == LAST) ? '0 : $past(beat_o) + 1'b1)));
endmodule

// File: rtl/bag_origin_reg.sv
module bag_origin_reg
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] origin_o,
  output order_e            order_o
);
  logic [ADDR_W-1:0] origin_q, origin_d;
  order_e            order_q, order_d;

  always_comb begin
    origin_d = origin_q;
    order_d  = order_q;
    if (cap) begin
      origin_d = start_i;
      order_d  = mode_i ? ORD_XOR : ORD_SEQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_q <= '0;
      order_q  <= ORD_SEQ;
    end else begin
      origin_q <= origin_d;
      order_q  <= order_d;
    end
  end

  assign origin_o = origin_q;
  assign order_o  = order_q;

  // R6
  origin_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(origin_o));

  // R8
  order_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(order_o));
endmodule

// File: rtl/bag_low_seq.sv
module bag_low_seq
  import bag_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = $clog2(BURST_LEN)
) (
  input  logic [BEAT_W-1:0] origin_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] seq_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign seq_lo = origin_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = origin_lo[b] ^ beat[b];
  end

  always_comb begin
    case (order)
      ORD_XOR: low_o = xor_lo;
      default: low_o = seq_lo;
    endcase
  end
endmodule

// File: rtl/bag_burst_addr_gen.sv
module bag_burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W   = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic              srst_n;
  logic              step_en;
  logic              do_load;
  logic [ADDR_W-1:0] origin;
  order_e            order;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  assign step_en = !hold_i;
  assign do_load = step_en && !adv_i;

  bag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bag_origin_reg #(.ADDR_W(ADDR_W)) u_origin (
    .clk(clk), .rst_n(srst_n), .cap(do_load), .start_i(start_i),
    .mode_i(mode_i), .origin_o(origin), .order_o(order)
  );

  bag_beat_ctr #(.BURST_LEN(BURST_LEN)) u_beat (
    .clk(clk), .rst_n(srst_n), .en(step_en), .clr(!adv_i), .inc(adv_i),
    .beat_o(beat)
  );

  bag_low_seq #(.BURST_LEN(BURST_LEN)) u_low (
    .origin_lo(origin[BEAT_W-1:0]), .beat(beat), .order(order), .low_o(low)
  );

  assign addr_o = {origin[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!srst_n)
    hold_i |=> ($stable(addr_o) && $stable(beat_o)));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && adv_i) |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && adv_i && order == ORD_SEQ) |=>
      (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  // R4
  xor_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && adv_i && order == ORD_XOR) |=>
      ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o))));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    do_load |=> (addr_o == $past(start_i)));
endmodule

// File: tb/sim_bag_burst_addr_gen.sv
module sim_bag_burst_addr_gen;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hold_i, adv_i, mode_i;
  logic [AW-1:0] start_i;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  int m_base, m_beat, m_mode;

  always #2.5 clk = ~clk;

  bag_burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i),
    .mode_i(mode_i), .start_i(start_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_beat = 0; m_mode = 0;
    end else if (!hold_i) begin
      if (!adv_i) begin
        m_base = int'(start_i); m_beat = 0; m_mode = int'(mode_i);
      end else begin
        m_beat = (m_beat + 1) % 4;
      end
    end
  end

  function automatic int exp_addr();
    int lo;
    lo = (m_mode != 0) ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic cyc(logic h, logic a, logic m, int s);
    hold_i = h; adv_i = a; mode_i = m; start_i = AW'(s);
    @(negedge clk);
    check({cur_req, " addr"}, int'(addr_o), exp_addr());
    check({cur_req, " beat"}, int'(beat_o), m_beat);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_i = 1'b1; adv_i = 1'b1; mode_i = 1'b0; start_i = '0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 addr", int'(addr_o), 0);
    check("R1 beat", int'(beat_o), 0);
    rst_n = 1'b1;
    repeat (3) cyc(1'b1, 1'b1, 1'b0, 0);

    // R3 and R5: sequential order from every low offset
    for (int s = 0; s < 4; s++) begin
      cur_req = "R3";
      cyc(1'b0, 1'b0, 1'b0, 32'h5A5A0 | s);
      check("R2 load", int'(addr_o), 32'h5A5A0 | s);
      repeat (4) cyc(1'b0, 1'b1, 1'b0, 0);
      cur_req = "R5";
      check("R5 wrap", int'(addr_o), 32'h5A5A0 | s);
      check("R5 beat", int'(beat_o), 0);
      cyc(1'b0, 1'b1, 1'b0, 0);
    end

    // R4: interleaved order from every low offset
    for (int s = 0; s < 4; s++) begin
      cur_req = "R4";
      cyc(1'b0, 1'b0, 1'b1, 32'h7FFF8 | s);
      repeat (5) cyc(1'b0, 1'b1, 1'b1, 0);
    end
    cyc(1'b0, 1'b0, 1'b1, 32'h00001);
    cyc(1'b0, 1'b1, 1'b1, 0);
    check("R4 second beat", int'(addr_o), 32'h00000);

    // R7: stall ignores loads and advances
    cur_req = "R7";
    cyc(1'b0, 1'b0, 1'b0, 32'h12342);
    cyc(1'b0, 1'b1, 1'b0, 0);
    cyc(1'b1, 1'b0, 1'b1, 32'h0FFFF);
    cyc(1'b1, 1'b1, 1'b0, 0);
    check("R7 held", int'(addr_o), 32'h12343);
    cyc(1'b0, 1'b1, 1'b0, 0);

    // R8: mode flip in mid-burst
    cur_req = "R8";
    cyc(1'b0, 1'b0, 1'b0, 32'h00101);
    cyc(1'b0, 1'b1, 1'b1, 0);
    cyc(1'b0, 1'b1, 1'b1, 0);
    check("R8 still sequential", int'(addr_o), 32'h00103);
    cyc(1'b0, 1'b0, 1'b1, 32'h00101);
    cyc(1'b0, 1'b1, 1'b0, 0);
    check("R8 still interleaved", int'(addr_o), 32'h00100);

    // R6 and R9: mixed pattern
    cur_req = "R9";
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0] & lf[5], lf[1] | lf[2], lf[3], {lf, lf[2:0]});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule